// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host controller to a PS/2 device over the two open-drain wires, clock and data. A one-cycle start pulse with a byte begins the exchange. The host first holds the clock low long enough to inhibit the device. It then drives the data line low as a request. At the same moment it lets go of the clock, so the device takes over clocking.

The device then generates the clock. The block places each data bit while the clock is low, least significant bit first, and follows the bits with an odd-parity bit. On the clock low after the parity cycle it releases the data line as the stop bit. It then waits for the device to acknowledge by pulling data low and then clock low. A single done pulse ends the exchange and reports whether the acknowledge arrived. A watchdog covers the whole exchange, so a silent or broken device cannot stall the host.

The block never drives a line high. Each line has a drive-low enable, and the line levels come back already synchronized. While busy, the block also raises a hold signal for a neighbouring receiver, so the outgoing bits are not taken in as a frame.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, both drive-low enables, `busy`, `done` and `ackSeen` are 0.
- R2: After an accepted start pulse, `clkDriveLow` is 1 for exactly `INHIBIT_CYCLES` clock cycles. `dataDriveLow` stays 0 during that time.
- R3: In the first cycle in which `clkDriveLow` returns to 0, `dataDriveLow` is 1 (the start bit).
- R4: Nine frame bits follow: the eight data bits, bit 0 first, then the parity bit. `dataDriveLow` = 1 sends a 0, and `dataDriveLow` = 0 sends a 1. Each bit is set up while the device holds the clock low. The data line is stable for the whole time the clock is high.
- R5: The parity bit is 1 when the byte contains an even number of ones and 0 otherwise.
- R6: On the first clock low after the parity bit's clock cycle, the block releases the data line. The device therefore reads the stop bit as 1.
- R7: When the device pulls data low and then clock low, `done` is 1 for exactly one cycle with `ackSeen` = 1. `ackSeen` keeps its value until the next accepted start.
- R8: If an exchange is not complete after `WATCHDOG_CYCLES` cycles of `busy`, both enables return to 0 and `done` pulses with `ackSeen` = 0.
- R9: When the block is not busy, neither drive-low enable is asserted.
- R10: `busy` is 1 from the cycle after an accepted start until the cycle in which `done` is 1. A start pulse during that time is ignored: the byte sent is unchanged and no further exchange follows.
- R11: `rxSuppress` is 1 in every cycle in which `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to send `txByte` |
| txByte | input | 8 | Command byte, sampled with an accepted start |
| clkLevel | input | 1 | Synchronized level of the PS/2 clock wire |
| dataLevel | input | 1 | Synchronized level of the PS/2 data wire |
| clkDriveLow | output | 1 | Pull the clock wire low when 1 |
| dataDriveLow | output | 1 | Pull the data wire low when 1 |
| busy | output | 1 | An exchange is in progress |
| done | output | 1 | One-cycle pulse when the exchange ends |
| ackSeen | output | 1 | The device acknowledged the last exchange |
| rxSuppress | output | 1 | Tells a neighbouring receiver to stop sampling |

## Verification
The assertions watch five rules on every cycle:
- Both enables are off while idle.
- The clock is never inhibited while data is pulled low.
- Data holds steady while the block waits for the clock to rise.
- `done` is a single-cycle pulse that ends `busy`.
- The watchdog count never passes its limit.

Only the bench scenarios can show the rest. These are the exact inhibit length and the bit order and parity values the device actually samples. They also cover the two timeout outcomes: a device that never clocks and a device that never acknowledges. The last is that a start pulse during a busy exchange leaves the sent byte untouched.

// File: rtl/ps2_cmd_tx_pkg.sv
package ps2_cmd_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_STOP_LOW,
    ST_ACK_DATA,
    ST_ACK_CLK
  } txState_t;

  typedef struct packed {
    logic loadByte;
    logic startBit;
    logic emitBit;
    logic releaseData;
    logic finishOk;
    logic finishFail;
  } txStrobe_t;

endpackage

// File: rtl/ps2_tx_datapath.sv
module ps2_tx_datapath
  import ps2_cmd_tx_pkg::*;
#(
  parameter int INHIBIT_CYCLES  = 5000,
  parameter int WATCHDOG_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  stb,
  input  logic [7:0] txByte,
  input  logic       inInhibit,
  input  logic       busy,
  output logic       inhibitDone,
  output logic       wdExpired,
  output logic       lastBit,
  output logic       dataDriveLow,
  output logic       done,
  output logic       ackSeen
);

  localparam int FRAME_BITS = 9;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int INH_W      = $clog2(INHIBIT_CYCLES + 1);
  localparam int WD_W       = $clog2(WATCHDOG_CYCLES + 1);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]      bitsLeft;
  logic [INH_W-1:0]      inhCnt;
  logic [WD_W-1:0]       wdCnt;

  assign lastBit     = (bitsLeft == '0);
  assign inhibitDone = (inhCnt == INH_W'(INHIBIT_CYCLES - 1));
  assign wdExpired   = (wdCnt == WD_W'(WATCHDOG_CYCLES - 1));

  // Frame shifter: parity sits above the data byte so it leaves last
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
    end else if (stb.loadByte) begin
      shiftReg <= {~^txByte, txByte};
      bitsLeft <= CNT_W'(FRAME_BITS);
    end else if (stb.emitBit) begin
      shiftReg <= shiftReg >> 1;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  // Data line drive-low register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataDriveLow <= 1'b0;
    end else if (stb.startBit) begin
      dataDriveLow <= 1'b1;
    end else if (stb.emitBit) begin
      dataDriveLow <= ~shiftReg[0];
    end else if (stb.releaseData || stb.finishOk || stb.finishFail || stb.loadByte) begin
      dataDriveLow <= 1'b0;
    end
  end

  // Inhibit timer
  always_ff @(posedge clk) begin
    if (!rstN || stb.loadByte) begin
      inhCnt <= '0;
    end else if (inInhibit && !inhibitDone) begin
      inhCnt <= inhCnt + 1'b1;
    end
  end

  // Whole-transfer watchdog
  always_ff @(posedge clk) begin
    if (!rstN || stb.loadByte) begin
      wdCnt <= '0;
    end else if (busy && !wdExpired) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  // Result flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      done <= stb.finishOk || stb.finishFail;
      if (stb.loadByte || stb.finishFail) begin
        ackSeen <= 1'b0;
      end else if (stb.finishOk) begin
        ackSeen <= 1'b1;
      end
    end
  end

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (wdCnt <= WD_W'(WATCHDOG_CYCLES - 1))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_ACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackSeen) |-> done); // R7

endmodule

// File: rtl/ps2_tx_ctrl.sv
module ps2_tx_ctrl
  import ps2_cmd_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      clkLevel,
  input  logic      dataLevel,
  input  logic      inhibitDone,
  input  logic      wdExpired,
  input  logic      lastBit,
  output txStrobe_t stb,
  output txState_t  state,
  output logic      busy,
  output logic      inInhibit,
  output logic      clkDriveLow
);

  txState_t nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    if (state != ST_IDLE && wdExpired) begin
      stb.finishFail = 1'b1;
      nextState      = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startPulse) begin
            stb.loadByte = 1'b1;
            nextState    = ST_INHIBIT;
          end
        end
        ST_INHIBIT: begin
          if (inhibitDone) begin
            stb.startBit = 1'b1;
            nextState    = ST_WAIT_LOW;
          end
        end
        ST_WAIT_LOW: begin
          if (!clkLevel) begin
            stb.emitBit = 1'b1;
            nextState   = ST_WAIT_HIGH;
          end
        end
        ST_WAIT_HIGH: begin
          if (clkLevel) begin
            nextState = lastBit ? ST_STOP_LOW : ST_WAIT_LOW;
          end
        end
        ST_STOP_LOW: begin
          if (!clkLevel) begin
            stb.releaseData = 1'b1;
            nextState       = ST_ACK_DATA;
          end
        end
        ST_ACK_DATA: begin
          if (!dataLevel) begin
            nextState = ST_ACK_CLK;
          end
        end
        ST_ACK_CLK: begin
          if (!clkLevel) begin
            stb.finishOk = 1'b1;
            nextState    = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  assign busy        = (state != ST_IDLE);
  assign inInhibit   = (state == ST_INHIBIT);
  assign clkDriveLow = inInhibit;

  AST_WD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wdExpired) |=> !busy); // R8

endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2_cmd_tx_pkg::*;
#(
  parameter int INHIBIT_CYCLES  = 5000,
  parameter int WATCHDOG_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [7:0] txByte,
  input  logic       clkLevel,
  input  logic       dataLevel,
  output logic       clkDriveLow,
  output logic       dataDriveLow,
  output logic       busy,
  output logic       done,
  output logic       ackSeen,
  output logic       rxSuppress
);

  txStrobe_t stb;
  txState_t  state;
  logic      inhibitDone;
  logic      wdExpired;
  logic      lastBit;
  logic      inInhibit;

  ps2_tx_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .clkLevel    (clkLevel),
    .dataLevel   (dataLevel),
    .inhibitDone (inhibitDone),
    .wdExpired   (wdExpired),
    .lastBit     (lastBit),
    .stb         (stb),
    .state       (state),
    .busy        (busy),
    .inInhibit   (inInhibit),
    .clkDriveLow (clkDriveLow)
  );

  ps2_tx_datapath #(
    .INHIBIT_CYCLES  (INHIBIT_CYCLES),
    .WATCHDOG_CYCLES (WATCHDOG_CYCLES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .txByte       (txByte),
    .inInhibit    (inInhibit),
    .busy         (busy),
    .inhibitDone  (inhibitDone),
    .wdExpired    (wdExpired),
    .lastBit      (lastBit),
    .dataDriveLow (dataDriveLow),
    .done         (done),
    .ackSeen      (ackSeen)
  );

  assign rxSuppress = busy;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!clkDriveLow && !dataDriveLow)); // R9

  AST_INHIBIT_DATA_FREE: assert property (@(posedge clk) disable iff (!rstN)
    clkDriveLow |-> !dataDriveLow); // R2

  AST_HIGH_PHASE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_HIGH && $past(state) == ST_WAIT_HIGH) |-> $stable(dataDriveLow)); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R10

endmodule

// File: tb/ps2_cmd_tx_tb.sv
module ps2_cmd_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int INH        = 20;
  localparam int WD         = 2000;
  localparam int LOW_T      = 6;
  localparam int HIGH_T     = 6;

  typedef struct {
    logic [7:0] b;
    int         mode; // 0 normal, 1 silent device, 2 no acknowledge
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [7:0] txByte = '0;
  logic devClkLow = 1'b0;
  logic devDataLow = 1'b0;
  logic clkDriveLow, dataDriveLow, busy, done, ackSeen, rxSuppress;
  logic clkLevel, dataLevel;

  assign clkLevel  = !(clkDriveLow || devClkLow);
  assign dataLevel = !(dataDriveLow || devDataLow);

  int checks = 0;
  int failures = 0;
  int busyCnt = 0;
  int inhCnt = 0;
  int suppressBad = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_cmd_tx #(.INHIBIT_CYCLES(INH), .WATCHDOG_CYCLES(WD)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .txByte(txByte),
    .clkLevel(clkLevel), .dataLevel(dataLevel),
    .clkDriveLow(clkDriveLow), .dataDriveLow(dataDriveLow),
    .busy(busy), .done(done), .ackSeen(ackSeen), .rxSuppress(rxSuppress)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (busy) busyCnt++;
    if (clkDriveLow) inhCnt++;
    if (busy && !rxSuppress) suppressBad++;
  endtask

  function automatic logic oddPar(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (b[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  // Device model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (busy && expQ.size() > 0) begin
        exp_t e;
        logic [7:0] got;
        logic par, stopBit, held;
        bit unstable;
        e = expQ[0];
        busyCnt = 1; inhCnt = clkDriveLow ? 1 : 0; suppressBad = 0;
        got = '0; par = 1'b0; stopBit = 1'b0; unstable = 0;
        while (clkDriveLow) tick();
        check(inhCnt == INH, "R2 inhibit length", inhCnt, INH);
        check(dataDriveLow == 1'b1, "R3 start bit with clock release", dataDriveLow, 1);
        if (e.mode != 1) begin
          repeat (3) tick();
          for (int i = 0; i < 10; i++) begin
            devClkLow = 1'b1;
            repeat (LOW_T) tick();
            devClkLow = 1'b0;
            tick();
            held = dataLevel;
            for (int k = 1; k < HIGH_T; k++) begin
              tick();
              if (dataLevel != held) unstable = 1;
            end
            if (i < 8) got[i] = held;
            else if (i == 8) par = held;
            else stopBit = held;
          end
          check(!unstable, "R4 data stable while clock high", unstable, 0);
          check(got == e.b, "R4 byte sampled LSB first", got, e.b);
          check(par == oddPar(e.b), "R5 parity bit", par, oddPar(e.b));
          check(stopBit == 1'b1, "R6 stop bit released", stopBit, 1);
          if (e.mode == 0) begin
            devDataLow = 1'b1;
            repeat (3) tick();
            devClkLow = 1'b1;
          end
        end
        while (!done) tick();
        void'(expQ.pop_front());
        check(!busy, "R10 busy falls with done", busy, 0);
        check(ackSeen == (e.mode == 0), "R7 R8 ackSeen result", ackSeen, (e.mode == 0));
        check(!clkDriveLow && !dataDriveLow, "R9 lines released at end",
              {clkDriveLow, dataDriveLow}, 0);
        check(suppressBad == 0, "R11 receiver hold while busy", suppressBad, 0);
        if (e.mode != 0)
          check(busyCnt == WD, "R8 watchdog length", busyCnt, WD);
        devClkLow = 1'b0;
        devDataLow = 1'b0;
        @(negedge clk);
        check(!done, "R7 done single cycle", done, 0);
        check(ackSeen == (e.mode == 0), "R7 ackSeen held", ackSeen, (e.mode == 0));
      end
    end
  end

  task automatic send(input logic [7:0] b, input int mode, input bit intrude);
    exp_t e;
    e.b = b; e.mode = mode;
    expQ.push_back(e);
    @(negedge clk);
    startPulse = 1'b1; txByte = b;
    @(negedge clk);
    startPulse = 1'b0; txByte = 8'h00;
    if (intrude) begin
      repeat (60) @(negedge clk);
      startPulse = 1'b1; txByte = ~b;
      @(negedge clk);
      startPulse = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    if (intrude) begin
      int extra = 0;
      repeat (30) begin
        @(negedge clk);
        if (busy) extra++;
      end
      check(extra == 0, "R10 start while busy ignored", extra, 0);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({clkDriveLow, dataDriveLow, busy, done, ackSeen} == 5'b0,
          "R1 reset state", {clkDriveLow, dataDriveLow, busy, done, ackSeen}, 0);
    send(8'hED, 0, 0);
    send(8'h00, 0, 0);
    send(8'hFF, 0, 0);
    send(8'h01, 0, 0);
    send(8'h07, 0, 0);
    send(8'hA5, 0, 1);
    send(8'hF4, 1, 0);
    send(8'h3C, 2, 0);
    send(8'h80, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule